// File: doc/BRIEF.md
# Selectable interrupt request router

This block gathers a set of internal event pulses into a single interrupt condition. It presents that condition on exactly one of four interrupt request lines. Software chooses the line by writing a line number from 0 to 3 into a selection register at offset 0x022 of the block's register space. Each line has a level output and a drive enable for the pad. The selected line is driven, and the other three have their enables low, so they float at the pad.

An event pulse counts only when its enable input is high. A counted event is recorded as a pending bit and raises the selected line. The host drains the pending set through a status read port. Each read returns one pending event, taking the lowest index first. The line falls only after a read that finds nothing pending and therefore returns an all-zero word. This ties deassertion to the host having seen an empty status queue, with no separate acknowledge.

Top module: `irq_route`

## Requirements
- R1: After reset the selection is line 0, line 0 is driven low, lines 1 to 3 have their drive enable low, and the status word reads 0x0000.
- R2: A write to offset 0x022 selects line wr_data[1:0] from the next clock. All higher data bits are ignored.
- R3: A write to any other offset leaves the selection unchanged.
- R4: At every cycle exactly one drive enable is high, the one for the selected line. Every unselected line has its level at 0.
- R5: An event pulse whose enable bit is high raises the selected line's level on the next clock.
- R6: An event pulse whose enable bit is low does not raise the line and does not become pending: a following read returns 0x0000.
- R7: A read strobe with events pending returns, on the next clock, one event as a status word with bit 15 set and bits 7:0 holding the event index. The lowest index goes first, and that event is cleared.
- R8: A read strobe with nothing pending returns 0x0000 on the next clock, and the line falls at that same clock.
- R9: While requests are active, reads that return a nonzero word leave the line high.
- R10: An enabled event in the same cycle as an all-zero read keeps the line high, and that event becomes pending.
- R11: Changing the selection while a request is active moves the high level to the new line on the next clock and floats the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | NUM_EVT | One-cycle event pulses |
| evt_en | input | NUM_EVT | Per-event enable bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | 16 | Register write data |
| rd_stb | input | 1 | Status read strobe |
| rd_data | output | 16 | Status word, valid the clock after rd_stb |
| irq_lvl | output | NUM_LINES | Level of each request line |
| irq_oe | output | NUM_LINES | Pad drive enable of each request line |

## Verification
Two functions can fall in the same cycle: the all-zero status read that would drop the line, and a newly arriving enabled event that must raise it. The bench drives both in the same cycle: the read strobe with an empty pending set, together with an event pulse. The scoreboard then expects a 0x0000 status word. It also expects the line still high on the next clock. The next read must return the new event's word. The same collision is also reached during a selection change, to show that the surviving level follows the newly chosen line.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int STAT_W = 16;
  localparam int IDX_W  = 8;

  // Status word: bit 15 marks a valid event, bits 7:0 carry its index.
  function automatic logic [STAT_W-1:0] make_status(input logic hit, input logic [IDX_W-1:0] idx);
    logic [STAT_W-1:0] w;
    w = '0;
    if (hit) begin
      w[STAT_W-1]  = 1'b1;
      w[IDX_W-1:0] = idx;
    end
    return w;
  endfunction

  // Isolates the lowest set bit of a vector (two's-complement trick).
  function automatic logic [63:0] lowest_bit(input logic [63:0] v);
    return v & (~v + 64'd1);
  endfunction
endpackage

// File: rtl/irq_pending_set.sv
module irq_pending_set
  import irq_route_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_take,
  input  logic               pop,
  output logic               pend_any,
  output logic [STAT_W-1:0]  stat_q
);
  logic [NUM_EVT-1:0] pend_q;
  logic [NUM_EVT-1:0] pop_mask;
  logic [IDX_W-1:0]   pop_idx;
  logic [63:0]        low64;

  assign pend_any = |pend_q;
  assign low64    = lowest_bit(64'(pend_q));
  assign pop_mask = pop ? low64[NUM_EVT-1:0] : '0;

  always_comb begin
    pop_idx = '0;
    for (int i = NUM_EVT-1; i >= 0; i--)
      if (pend_q[i]) pop_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      stat_q <= '0;
    end else begin
      // New events win over a pop of the same bit.
      pend_q <= (pend_q & ~pop_mask) | evt_take;
      if (pop) stat_q <= make_status(pend_any, pop_idx);
    end
  end
endmodule

// File: rtl/irq_sel_reg.sv
module irq_sel_reg #(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 16,
  parameter int          NUM_LINES  = 4,
  parameter logic [11:0] SEL_OFFSET = 12'h022,
  localparam int         SEL_W      = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel_q
);
  logic hit;
  assign hit = wr_en && (wr_addr == ADDR_W'(SEL_OFFSET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sel_q <= '0;
    else if (hit) sel_q <= wr_data[SEL_W-1:0];
  end
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
  parameter int  NUM_LINES = 4,
  localparam int SEL_W     = $clog2(NUM_LINES)
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic                 active,
  output logic [NUM_LINES-1:0] lvl,
  output logic [NUM_LINES-1:0] oe
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic chosen;
    assign chosen = (sel == SEL_W'(g));
    assign oe[g]  = chosen;
    assign lvl[g] = chosen & active;
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
#(
  parameter int          NUM_EVT    = 8,
  parameter int          NUM_LINES  = 4,
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] SEL_OFFSET = 12'h022
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   evt_pulse,
  input  logic [NUM_EVT-1:0]   evt_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [15:0]          wr_data,
  input  logic                 rd_stb,
  output logic [15:0]          rd_data,
  output logic [NUM_LINES-1:0] irq_lvl,
  output logic [NUM_LINES-1:0] irq_oe
);
  localparam int SEL_W = $clog2(NUM_LINES);

  // Named internal events, brought out for the checker.
  logic [NUM_EVT-1:0] evt_take;
  logic               evt_accept;
  logic               pend_any;
  logic               zero_read;
  logic               irq_active;
  logic [SEL_W-1:0]   sel_q;

  assign evt_take   = evt_pulse & evt_en;
  assign evt_accept = |evt_take;
  assign zero_read  = rd_stb && !pend_any;

  irq_pending_set #(.NUM_EVT(NUM_EVT)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_take(evt_take), .pop(rd_stb),
    .pend_any(pend_any), .stat_q(rd_data)
  );

  irq_sel_reg #(.ADDR_W(ADDR_W), .DATA_W(16), .NUM_LINES(NUM_LINES),
                .SEL_OFFSET(SEL_OFFSET)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel_q(sel_q)
  );

  // Setting wins: an event arriving with the empty read keeps the request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_active <= 1'b0;
    else if (evt_accept) irq_active <= 1'b1;
    else if (zero_read)  irq_active <= 1'b0;
  end

  irq_line_drive #(.NUM_LINES(NUM_LINES)) u_drive (
    .sel(sel_q), .active(irq_active), .lvl(irq_lvl), .oe(irq_oe)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 12,
  parameter logic [11:0] SEL_OFFSET = 12'h022,
  localparam int SEL_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 evt_accept,
  input logic                 zero_read,
  input logic                 pend_any,
  input logic                 rd_stb,
  input logic                 irq_active,
  input logic [SEL_W-1:0]     sel_q,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [15:0]          wr_data,
  input logic [15:0]          rd_data,
  input logic [NUM_LINES-1:0] irq_lvl,
  input logic [NUM_LINES-1:0] irq_oe
);
  assert_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> irq_lvl[sel_q]);
  assert_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_read && !evt_accept) |=> (!irq_active && rd_data == 16'h0000));
  assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_read && evt_accept) |=> irq_active);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && !zero_read) |=> irq_active);
  assert_onehot_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq_oe) == 1) && irq_oe[sel_q] && ((irq_lvl & ~irq_oe) == '0));
  assert_sel_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(SEL_OFFSET)) |=> (sel_q == $past(wr_data[SEL_W-1:0])));
  assert_sel_other_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr == ADDR_W'(SEL_OFFSET))) |=> $stable(sel_q));
  assert_pop_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && pend_any) |=> rd_data[15]);
  assert_move_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && !zero_read && $changed(sel_q)) |-> irq_lvl[sel_q]);
endmodule

bind irq_route irq_route_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .SEL_OFFSET(SEL_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_accept(evt_accept), .zero_read(zero_read),
  .pend_any(pend_any), .rd_stb(rd_stb), .irq_active(irq_active), .sel_q(sel_q),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data),
  .irq_lvl(irq_lvl), .irq_oe(irq_oe)
);

// File: tb/irq_route_tb.sv
`timescale 1ns/1ps
module irq_route_tb;
  localparam int NE = 8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NE-1:0] evt_pulse = '0, evt_en = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_stb = 1'b0;
  logic [15:0] rd_data;
  logic [3:0]  irq_lvl, irq_oe;

  int checks = 0, errors = 0;
  logic [NE-1:0] m_pend = '0;
  logic          m_act  = 1'b0;
  int            m_sel  = 0;
  logic [15:0]   exp_q[$];
  string         tag_q[$];
  logic          stb_q = 1'b0;

  always #10 clk = ~clk;

  irq_route u_dut (.clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_en(evt_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq_lvl(irq_lvl), .irq_oe(irq_oe));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected status: scan upward for the first pending index.
  function automatic logic [15:0] model_word();
    for (int i = 0; i < NE; i++)
      if (m_pend[i]) return 16'h8000 | 16'(i);
    return 16'h0000;
  endfunction

  task automatic check_lines(input string tag);
    check({tag, " oe"},  16'(irq_oe),  16'(4'b0001 << m_sel));
    check({tag, " lvl"}, 16'(irq_lvl), 16'(m_act ? (4'b0001 << m_sel) : 4'b0000));
  endtask

  // Driver: one cycle of stimulus; pushes expected read result on the scoreboard.
  task automatic cycle(input logic rd, input logic [NE-1:0] ev, input string tag);
    logic [15:0] w;
    logic [NE-1:0] take;
    @(negedge clk);
    rd_stb = rd; evt_pulse = ev;
    take = ev & evt_en;
    if (rd) begin
      w = model_word();
      exp_q.push_back(w); tag_q.push_back(tag);
      if (w[15]) m_pend[w[7:0]] = 1'b0;
      else if (take == '0) m_act = 1'b0;
    end
    m_pend = m_pend | take;
    if (take != '0) m_act = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; evt_pulse = '0;
  endtask

  task automatic write_reg(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 12'h022) m_sel = int'(d[1:0]);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: pops the scoreboard the cycle after each read strobe.
  always @(posedge clk) stb_q <= rd_stb;
  always @(negedge clk) begin
    if (stb_q) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_lines("R1 reset");
    check("R1 status", rd_data, 16'h0000);
    cycle(1'b1, '0, "R1 empty read");
    evt_en = 8'b1111_1011;
    cycle(1'b0, 8'h04, "R6 disabled");
    check_lines("R6 line low");
    cycle(1'b1, '0, "R6 nothing pending");
    cycle(1'b0, 8'h22, "R5 two events");
    check_lines("R5 raised");
    cycle(1'b1, '0, "R7 lowest first");
    check_lines("R9 still high");
    cycle(1'b1, '0, "R7 next index");
    check_lines("R9 still high 2");
    cycle(1'b1, '0, "R8 zero read");
    check_lines("R8 fell");
    write_reg(12'h022, 16'hFFF2);
    check_lines("R2 upper bits ignored");
    write_reg(12'h024, 16'h0003);
    check_lines("R3 other offset");
    cycle(1'b0, 8'h01, "R5 on line 2");
    check_lines("R5 line 2 high");
    write_reg(12'h022, 16'h0003);
    check_lines("R11 moved to line 3");
    cycle(1'b1, '0, "R7 index 0");
    cycle(1'b1, 8'h10, "R10 zero read with event");
    check_lines("R10 kept high");
    cycle(1'b1, '0, "R10 event pending");
    write_reg(12'h022, 16'h0001);
    check_lines("R11 moved to line 1");
    cycle(1'b1, 8'h80, "R10 collision on line 1");
    check_lines("R10 line 1 high");
    cycle(1'b1, '0, "R7 index 7");
    cycle(1'b1, '0, "R8 final zero");
    check_lines("R8 final low");
    repeat (2) @(negedge clk);
    check("R7 scoreboard drained", 16'(exp_q.size()), 16'h0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule